// File: doc/BRIEF.md
# Floating-Point Branch Condition Evaluator

This block decides whether a floating-point conditional branch is taken. It takes a 6-bit predicate code from the instruction and the current 32-bit floating-point status word. From the status word it uses only the negative, zero and not-a-number condition bits, and it applies the truth function that the predicate selects.

The 32 legal predicates come in two halves of sixteen. Both halves use the same truth functions. In the upper half, a not-a-number operand also raises a branch-on-unordered exception request. Codes above 31 are rejected: the block flags them as invalid and holds the taken output low.

By default the three results are registered, so they appear one clock after the inputs are sampled. A parameter selects a purely combinational variant instead.

Top module: `fp_cond_eval`

## Requirements
- R1: Predicate low nibble 0 (codes 0 and 16) is never taken; low nibble 15 (codes 15 and 31) is always taken.
- R2: Low nibble 1 is taken when Z is set; low nibble 14 is taken when Z is clear.
- R3: Low nibbles 2 to 5 are taken as follows: 2 when none of A, Z, N is set; 3 when Z, or when A and N are both clear; 4 when N is set and A and Z are clear; 5 when Z, or when N is set and A is clear.
- R4: Low nibbles 6 to 9 are taken as follows: 6 when A and Z are both clear; 7 when A is clear; 8 when A is set; 9 when A or Z is set.
- R5: Low nibbles 10 to 13 are taken as follows: 10 when A, or when N and Z are both clear; 11 when A, Z, or N clear; 12 when A, or when N is set and Z is clear; 13 when any of A, Z, N is set.
- R6: Codes 16 to 31 give the same taken value as the code that has the same low four bits in the range 0 to 15.
- R7: The unordered exception output is 1 exactly when the code is 16 to 31 and A is set; codes 0 to 15 never raise it.
- R8: Codes 32 to 63 set the invalid output and force both the taken output and the exception output to 0. The invalid output is 0 for codes 0 to 31.
- R9: Condition bits sit in the status word at N = bit 27, Z = bit 26, I = bit 25 and A = bit 24. All other bits, and I itself, have no effect on any output.
- R10: With the default registered setting, outputs reflect the inputs sampled at the previous rising clock edge, and all outputs are 0 while reset (active low) is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered outputs |
| rst_n | input | 1 | Active-low reset, clears the outputs |
| pred_i | input | 6 | Predicate code |
| fpsr_i | input | 32 | Floating-point status word |
| taken_o | output | 1 | Branch taken |
| bad_pred_o | output | 1 | Predicate code above 31 |
| unord_exc_o | output | 1 | Branch-on-unordered exception request |

## Verification
With the registered default, all three results are due one rising edge after the inputs are applied. The bench drives the predicate and status word on a falling edge. It then compares the outputs at the next falling edge, one rising edge later and half a period away from any edge. Each new stimulus follows only after the previous one has been checked, so each result is tied to exactly one input pair. The reset check samples on a falling edge while reset is still held.

// File: rtl/fp_cond_eval.sv
module fp_cond_eval #(
  parameter int SR_W    = 32,
  parameter int N_BIT   = 27,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      pred_i,
  input  logic [SR_W-1:0] fpsr_i,
  output logic            taken_o,
  output logic            bad_pred_o,
  output logic            unord_exc_o
);
  localparam int Z_BIT = N_BIT - 1;
  localparam int A_BIT = N_BIT - 3;

  logic n, z, a;
  logic fn, bad, sig, taken_c, exc_c;

  assign n = fpsr_i[N_BIT];
  assign z = fpsr_i[Z_BIT];
  assign a = fpsr_i[A_BIT];

  always_comb begin
    unique case (pred_i[3:0])
      4'd0:  fn = 1'b0;
      4'd1:  fn = z;
      4'd2:  fn = !(a | z | n);
      4'd3:  fn = z | !(a | n);
      4'd4:  fn = n & !a & !z;
      4'd5:  fn = z | (n & !a);
      4'd6:  fn = !(a | z);
      4'd7:  fn = !a;
      4'd8:  fn = a;
      4'd9:  fn = a | z;
      4'd10: fn = a | !(n | z);
      4'd11: fn = a | z | !n;
      4'd12: fn = a | (n & !z);
      4'd13: fn = a | z | n;
      4'd14: fn = !z;
      default: fn = 1'b1;
    endcase
  end

  assign bad     = pred_i[5];
  assign sig     = pred_i[4] & !bad;
  assign taken_c = fn & !bad;
  assign exc_c   = sig & a;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          taken_o     <= 1'b0;
          bad_pred_o  <= 1'b0;
          unord_exc_o <= 1'b0;
        end else begin
          taken_o     <= taken_c;
          bad_pred_o  <= bad;
          unord_exc_o <= exc_c;
        end
      end

      p_invalid_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (bad_pred_o == ($past(pred_i) > 6'd31)));
      p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pred_o |-> (!taken_o && !unord_exc_o));
      p_exc_on_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (unord_exc_o == ($past(pred_i[5:4]) == 2'b01 && $past(fpsr_i[A_BIT]))));
      p_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_i == 6'd0 || pred_i == 6'd16) |=> !taken_o);
      p_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_i == 6'd15 || pred_i == 6'd31) |=> taken_o);
      p_ordered_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_i[5] == 1'b0 && pred_i[3:0] == 4'd7 && fpsr_i[A_BIT]) |=> !taken_o);
    end else begin : g_comb
      assign taken_o     = taken_c;
      assign bad_pred_o  = bad;
      assign unord_exc_o = exc_c;

      always_comb begin
        if (rst_n) begin
          a_invalid_quiet_r8: assert (!(bad_pred_o && (taken_o || unord_exc_o)));
        end
      end
    end
  endgenerate
endmodule

// File: tb/fp_cond_eval_tb.sv
module fp_cond_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pred = '0;
  logic [31:0] sr = '0;
  logic        taken, bad, exc;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fp_cond_eval u_dut (
    .clk(clk), .rst_n(rst_n), .pred_i(pred), .fpsr_i(sr),
    .taken_o(taken), .bad_pred_o(bad), .unord_exc_o(exc)
  );

  function automatic logic [2:0] model(logic [5:0] p, logic [31:0] s);
    logic nn, zz, aa, t;
    nn = s[27]; zz = s[26]; aa = s[24];
    case (p[3:0])
      0: t = 0;
      1: t = zz;
      2: t = !aa && !zz && !nn;
      3: t = zz || (!aa && !nn);
      4: t = nn && !aa && !zz;
      5: t = zz || (nn && !aa);
      6: t = !aa && !zz;
      7: t = !aa;
      8: t = aa;
      9: t = aa || zz;
      10: t = aa || (!nn && !zz);
      11: t = aa || zz || !nn;
      12: t = aa || (nn && !zz);
      13: t = aa || zz || nn;
      14: t = !zz;
      default: t = 1;
    endcase
    if (p >= 32) return 3'b100;
    return {1'b0, t, (p >= 16) && aa};
  endfunction

  function automatic string tag(logic [5:0] p);
    if (p >= 32) return "R8";
    if (p >= 16) return "R6/R7";
    case (p[3:0])
      0, 15: return "R1";
      1, 14: return "R2";
      2, 3, 4, 5: return "R3";
      6, 7, 8, 9: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pred=%0d sr=%h got {bad,taken,exc}=%b expected %b",
               req, pred, sr, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] p, logic [31:0] s, string req);
    pred = p;
    sr = s;
    @(negedge clk);
    check(req, {bad, taken, exc}, model(p, s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {bad, taken, exc}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 64; p++)
      for (int c = 0; c < 16; c++) begin
        logic [31:0] s;
        s = {4'h0, c[3:0], 24'h0};
        apply(p[5:0], s, tag(p[5:0]));
      end
    apply(6'd2, 32'hF0FF_FFFF, "R9 other bits set");
    apply(6'd2, 32'h0200_0000, "R9 I bit ignored");
    apply(6'd24, 32'h0100_0000, "R7 signaling nan");
    apply(6'd8, 32'h0100_0000, "R7 non-signaling nan");
    apply(6'd47, 32'h0F00_0000, "R8 invalid all flags");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] p;
      p = 6'($urandom_range(0, 63));
      apply(p, $urandom(), {tag(p), " random"});
    end
    rst_n = 1'b0;
    pred = 6'd15;
    @(negedge clk);
    check("R10 reset mid-run", {bad, taken, exc}, 3'b000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule